// File: doc/BRIEF.md
# Loop Network Secondary Station Repeater

This block sits in the bit-serial data path of a station on a ring-shaped network that uses bit-oriented framing. A strobe, `bit_en`, marks each line bit time. On each strobe the block samples one incoming bit and updates its outgoing bit. In the normal case it simply passes the ring along, so every bit it receives reappears on its output one bit time later.

The ring master gives transmit permission by sending an end-of-poll pattern: a 0 followed by seven 1s. On the line, zero insertion keeps this pattern unique. A station that holds a frame watches for the pattern. When it sees it, the station sends 0 in place of the seventh 1, so the pattern leaves as an opening flag (0 then six 1s then 0). The station then sends its own payload with zero insertion and closes with a fresh end-of-poll. A station further along the ring can then use that closing pattern in the same way and append its own frame. While its own frame is on the line, the block ignores what arrives. It goes back to echoing on the strobe after the closing pattern ends.

The payload comes in as bytes on a valid/ready stream. `byte_ready` rises only when the block can take a byte. A byte moves on a clock edge where `byte_valid` and `byte_ready` are both high. While `byte_valid` is high and the byte has not been taken, the source must hold `byte_data` and `byte_last` steady. The block never asks for more bytes after it has taken the byte marked last. CRC, receive-side frame decoding and line coding belong to other blocks.

Top module: `loop_station`

## Requirements
- R1: With no conversion taking place, `tx_bit` after each strobe equals the `rx_bit` sampled on that strobe, and it changes only on strobes.
- R2: An end-of-poll is seven consecutive 1s on `rx_bit` directly after a received 0. A run of six 1s does not count, and neither does a run of 1s with no 0 received since reset.
- R3: When a frame is pending and `loop_en` is high, the strobe that carries the seventh 1 of an end-of-poll outputs 0 instead of 1. On the same edge `sending` rises.
- R4: On the strobes right after that 0, the payload bytes go out in acceptance order, each byte least significant bit first. Incoming bits have no effect on the output during this time.
- R5: In the payload, including after its final bit, a 0 is inserted after every five consecutive 1s. The flag and the closing pattern get no insertion.
- R6: After the payload the block sends 0 and then seven 1s. On the edge of the last 1, `frame_done` pulses high for one clock and `sending` falls.
- R7: The first strobe after the closing pattern echoes `rx_bit` again, and a new pending frame can take the very next end-of-poll.
- R8: While `loop_en` is low, no end-of-poll is converted and the block only repeats the line.
- R9: With no frame pending, an end-of-poll passes through unchanged. A `frame_req` pulse while `sending` is high is ignored.
- R10: `byte_ready` is low unless a frame is pending or a payload that has not yet taken its last byte is being sent. While a frame waits for a poll, exactly one byte is prefetched.
- R11: If a payload bit slot finds no byte loaded and the last byte has not yet been taken, the closing pattern begins in that slot: 0 and then seven 1s.
- R12: Reset sets `tx_bit` to 1, drops any pending frame, and selects repeating. `sending`, `frame_done` and `byte_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-clock strobe per line bit time |
| rx_bit | input | 1 | Incoming line bit, sampled on strobes |
| tx_bit | output | 1 | Outgoing line bit, registered |
| loop_en | input | 1 | Allows end-of-poll conversion when high |
| frame_req | input | 1 | Pulse that marks a frame as pending |
| byte_data | input | DATA_W | Payload byte, sent LSB first |
| byte_valid | input | 1 | Payload byte offered |
| byte_last | input | 1 | Offered byte ends the frame |
| byte_ready | output | 1 | Block takes the offered byte this clock |
| sending | output | 1 | Own payload or closing pattern on the line |
| frame_done | output | 1 | One-clock pulse at the end of the closing pattern |

## Verification
The hardest case to reach from the ports is the moment a run of 1s crosses a byte boundary and also ends the frame. The stuffed 0 then has to come out before the closing pattern, while byte intake is already shut off. The stimulus reaches this case with two frames. In the first, the five-1 run spans two bytes. The second ends in five 1s and is sent back to back with the first. A starved byte source drives the underrun case, and a frame that is held pending while looping is disabled checks the single-byte prefetch.

// File: rtl/loop_station_pkg.sv
`timescale 1ns/1ps
package loop_station_pkg;
  typedef enum logic [1:0] {
    ST_REPEAT  = 2'd0,
    ST_PAYLOAD = 2'd1,
    ST_CLOSE   = 2'd2
  } st_e;
endpackage

// File: rtl/loop_eop_detect.sv
`timescale 1ns/1ps
module loop_eop_detect #(
  parameter int EOP_ONES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic clear,
  input  logic rx_bit,
  output logic hit
);
  localparam int RW = $clog2(EOP_ONES + 1);

  logic [RW-1:0] run;
  logic          zero_seen;

  // the strobe carrying the last 1 of "0 then EOP_ONES ones"
  assign hit = bit_en && !clear && rx_bit && zero_seen && (run == RW'(EOP_ONES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= '0;
      zero_seen <= 1'b0;
    end else if (clear) begin
      run       <= '0;
      zero_seen <= 1'b0;
    end else if (bit_en) begin
      if (!rx_bit) begin
        run       <= '0;
        zero_seen <= 1'b1;
      end else if (run != RW'(EOP_ONES)) begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/loop_byte_feeder.sv
`timescale 1ns/1ps
module loop_byte_feeder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_en,
  input  logic              pop,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  input  logic              byte_last,
  output logic              byte_ready,
  output logic              full,
  output logic              cur_bit,
  output logic              cur_last_bit
);
  localparam int BW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     left;
  logic              last_q;
  logic              final_pop;

  assign final_pop    = pop && (left == BW'(1));
  assign byte_ready   = accept_en && (!full || final_pop);
  assign cur_bit      = sh[0];
  assign cur_last_bit = last_q && (left == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      full   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (pop) begin
        sh   <= sh >> 1;
        left <= left - 1'b1;
        if (final_pop) full <= 1'b0;
      end
      if (byte_valid && byte_ready) begin
        sh     <= byte_data;
        left   <= BW'(DATA_W);
        full   <= 1'b1;
        last_q <= byte_last;
      end
    end
  end
endmodule

// File: rtl/loop_station.sv
`timescale 1ns/1ps
module loop_station
  import loop_station_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int EOP_ONES  = 7,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  output logic              tx_bit,
  input  logic              loop_en,
  input  logic              frame_req,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  input  logic              byte_last,
  output logic              byte_ready,
  output logic              sending,
  output logic              frame_done
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int CW = $clog2(EOP_ONES + 1);

  st_e           st;
  logic          pending, got_last, tx_q, done_q;
  logic [OW-1:0] ones;
  logic [CW-1:0] close_cnt;

  logic eop_hit, convert, stuff_due, pop, accept_en, take, fills_run;
  logic fd_full, fd_bit, fd_last_bit;

  loop_eop_detect #(.EOP_ONES(EOP_ONES)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .clear  (st != ST_REPEAT),
    .rx_bit (rx_bit),
    .hit    (eop_hit)
  );

  assign stuff_due = (ones == OW'(STUFF_RUN));
  assign pop       = bit_en && (st == ST_PAYLOAD) && !stuff_due && fd_full;
  assign accept_en = ((st == ST_REPEAT) && pending) || ((st == ST_PAYLOAD) && !got_last);
  assign take      = byte_valid && byte_ready;
  assign convert   = eop_hit && pending && loop_en && (st == ST_REPEAT);
  assign fills_run = fd_bit && (ones == OW'(STUFF_RUN - 1));

  loop_byte_feeder #(.DATA_W(DATA_W)) u_feed (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_en    (accept_en),
    .pop          (pop),
    .byte_data    (byte_data),
    .byte_valid   (byte_valid),
    .byte_last    (byte_last),
    .byte_ready   (byte_ready),
    .full         (fd_full),
    .cur_bit      (fd_bit),
    .cur_last_bit (fd_last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_REPEAT;
      pending   <= 1'b0;
      got_last  <= 1'b0;
      tx_q      <= 1'b1;
      done_q    <= 1'b0;
      ones      <= '0;
      close_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (take && byte_last) got_last <= 1'b1;
      if (frame_req && (st == ST_REPEAT) && !convert) pending <= 1'b1;
      if (bit_en) begin
        case (st)
          ST_REPEAT: begin
            if (convert) begin
              tx_q    <= 1'b0;
              st      <= ST_PAYLOAD;
              pending <= 1'b0;
              ones    <= '0;
            end else begin
              tx_q <= rx_bit;
            end
          end
          ST_PAYLOAD: begin
            if (stuff_due) begin
              tx_q <= 1'b0;
              ones <= '0;
              if (!fd_full && got_last) begin
                st        <= ST_CLOSE;
                close_cnt <= '0;
              end
            end else if (fd_full) begin
              tx_q <= fd_bit;
              ones <= fd_bit ? ones + 1'b1 : '0;
              if (fd_last_bit && !fills_run) begin
                st        <= ST_CLOSE;
                close_cnt <= '0;
              end
            end else begin
              // starved slot: this 0 opens the closing pattern
              tx_q      <= 1'b0;
              st        <= ST_CLOSE;
              close_cnt <= CW'(1);
            end
          end
          ST_CLOSE: begin
            tx_q <= (close_cnt != '0);
            if (close_cnt == CW'(EOP_ONES)) begin
              st       <= ST_REPEAT;
              done_q   <= 1'b1;
              got_last <= 1'b0;
            end else begin
              close_cnt <= close_cnt + 1'b1;
            end
          end
          default: st <= ST_REPEAT;
        endcase
      end
    end
  end

  assign tx_bit     = tx_q;
  assign frame_done = done_q;
  assign sending    = (st == ST_PAYLOAD) || (st == ST_CLOSE);
endmodule

// File: rtl/loop_station_checker.sv
`timescale 1ns/1ps
module loop_station_checker
  import loop_station_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic rx_bit,
  input logic tx_bit,
  input logic loop_en,
  input logic sending,
  input logic frame_done,
  input logic byte_ready,
  input logic pending,
  input logic eop_hit,
  input st_e  st
);
  logic       pay_q;
  logic [3:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= 1'b0;
      run   <= '0;
    end else begin
      pay_q <= bit_en && (st == ST_PAYLOAD);
      if (pay_q) run <= tx_bit ? ((run == 4'hF) ? run : run + 1'b1) : 4'd0;
      else if (!sending) run <= '0;
    end
  end

  assert_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && st == ST_REPEAT && !(eop_hit && pending && loop_en)) |=> (tx_bit == $past(rx_bit)));

  assert_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> (!tx_bit && $past(eop_hit)));

  assert_stuff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 4'(STUFF_RUN));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(sending) && !sending && tx_bit));

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !sending) |=> !sending);

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (pending || sending));
endmodule

bind loop_station loop_station_checker #(.STUFF_RUN(STUFF_RUN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .rx_bit     (rx_bit),
  .tx_bit     (tx_bit),
  .loop_en    (loop_en),
  .sending    (sending),
  .frame_done (frame_done),
  .byte_ready (byte_ready),
  .pending    (pending),
  .eop_hit    (eop_hit),
  .st         (st)
);

// File: tb/loop_station_bench.sv
`timescale 1ns/1ps
module loop_station_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rx_bit = 1'b1, loop_en = 1'b1, frame_req = 1'b0;
  logic [7:0] byte_data;
  logic       byte_valid, byte_last, byte_ready, tx_bit, sending, frame_done;

  logic [7:0] fbytes [4];
  int         flen = 0, idx = 0;
  logic       src_on = 1'b0, src_clr = 1'b1;
  int         checks = 0, errors = 0;
  logic       exp_bits [64];
  int         exp_len = 0;

  always #4 clk = ~clk;

  assign byte_valid = src_on && (idx < flen);
  assign byte_data  = fbytes[idx[1:0]];
  assign byte_last  = (idx == flen - 1);

  always @(posedge clk) begin
    if (src_clr) idx <= 0;
    else if (byte_valid && byte_ready) idx <= idx + 1;
  end

  loop_station u_loop_station (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .loop_en(loop_en), .frame_req(frame_req), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_last(byte_last), .byte_ready(byte_ready),
    .sending(sending), .frame_done(frame_done)
  );

  // {rx_bit, expected tx_bit}, looping on, nothing pending
  localparam logic [1:0] VEC [20] = '{
    2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11,
    2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic r, output logic o, output logic d);
    @(negedge clk); rx_bit = r; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0; o = tx_bit; d = frame_done;
    @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk); frame_req = 1'b1;
    @(negedge clk); frame_req = 1'b0;
  endtask

  task automatic build(input int n);
    int ones = 0;
    exp_len = 0;
    for (int b = 0; b < n; b++) begin
      for (int k = 0; k < 8; k++) begin
        exp_bits[exp_len++] = fbytes[b][k];
        ones = fbytes[b][k] ? ones + 1 : 0;
        if (ones == 5) begin exp_bits[exp_len++] = 1'b0; ones = 0; end
      end
    end
    exp_bits[exp_len++] = 1'b0;
    for (int k = 0; k < 7; k++) exp_bits[exp_len++] = 1'b1;
  endtask

  // 0 then seven 1s; conv selects whether the seventh 1 becomes 0
  task automatic send_eop(input bit conv, input string tag);
    logic o, d;
    strobe(1'b0, o, d); check(o == 1'b0, tag, o, 0);
    for (int k = 0; k < 6; k++) begin
      strobe(1'b1, o, d); check(o == 1'b1, tag, o, 1);
    end
    strobe(1'b1, o, d);
    check(o == !conv, tag, o, !conv);
    check(sending == conv, tag, sending, conv);
  endtask

  task automatic send_stream(input string tag, input bit mid_req);
    logic o, d;
    for (int i = 0; i < exp_len; i++) begin
      if (mid_req && i == 3) pulse_req();
      strobe((i % 3) == 0, o, d);
      check(o == exp_bits[i], tag, o, exp_bits[i]);
    end
    check(d == 1'b1, "R6 frame_done", d, 1);
    check(sending == 1'b0, "R6 sending falls", sending, 0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic o, d;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(tx_bit == 1'b1, "R12 tx_bit", tx_bit, 1);
    check(!sending && !frame_done && !byte_ready, "R12 outputs", {sending, frame_done, byte_ready}, 0);
    rst_n = 1'b1; src_clr = 1'b0;
    @(negedge clk);

    // R1 / R9: table walk, plain echo incl. an end-of-poll with nothing pending
    foreach (VEC[i]) begin
      strobe(VEC[i][1], o, d);
      check(o == VEC[i][0], "R1 R9 echo", o, VEC[i][0]);
      check(sending == 1'b0, "R9 no conversion", sending, 0);
    end

    // R8 / R10: frame pending while looping disabled
    fbytes[0] = 8'hFF; fbytes[1] = 8'h1F; flen = 2; src_on = 1'b1;
    loop_en = 1'b0;
    pulse_req();
    repeat (4) @(negedge clk);
    check(idx == 1, "R10 one byte prefetched", idx, 1);
    check(byte_ready == 1'b0, "R10 ready low when full", byte_ready, 0);
    send_eop(1'b0, "R8 loop disabled echo");

    // R2: six 1s then 0 does not qualify
    loop_en = 1'b1;
    strobe(1'b0, o, d); check(o == 1'b0, "R2 short run", o, 0);
    for (int k = 0; k < 6; k++) begin
      strobe(1'b1, o, d); check(o == 1'b1, "R2 short run", o, 1);
    end
    check(sending == 1'b0, "R2 no conversion", sending, 0);

    // R3 R4 R5 R6: frame with a run crossing the byte boundary
    send_eop(1'b1, "R3 flag conversion");
    build(2);
    send_stream("R4 R5 payload stream", 1'b0);
    check(idx == 2, "R10 all bytes taken", idx, 2);

    // R7 R5 R9: back-to-back frame ending in five 1s, request during send ignored
    src_clr = 1'b1; @(negedge clk); src_clr = 1'b0;
    fbytes[0] = 8'hF8; flen = 1;
    pulse_req();
    repeat (3) @(negedge clk);
    send_eop(1'b1, "R7 back-to-back conversion");
    build(1);
    send_stream("R5 trailing stuff", 1'b1);
    strobe(1'b0, o, d); check(o == 1'b0, "R7 echo resumes", o, 0);
    send_eop(1'b0, "R9 request during send ignored");

    // R11: starved source
    src_on = 1'b0; src_clr = 1'b1; @(negedge clk); src_clr = 1'b0;
    pulse_req();
    send_eop(1'b1, "R11 flag");
    build(0);
    send_stream("R11 underrun close", 1'b0);

    // R12: reset drops a pending frame
    pulse_req();
    strobe(1'b0, o, d);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(tx_bit == 1'b1, "R12 tx_bit after reset", tx_bit, 1);
    rst_n = 1'b1;
    send_eop(1'b0, "R12 pending cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule